// File: doc/BRIEF.md
# Two-Sided Register File with Shared Cross Bus

This block holds the architectural registers of a processor core that is split into two execution sides, A and B. Each side owns a bank of `NREG` registers of `DW` bits. Its functional units read that bank through `NLOC` independent local read ports. A unit on one side reaches the other side's bank only over a single shared cross bus. That bus carries at most one cross read and one cross write in any clock cycle.

Every register address is `AW = log2(NREG)+1` bits wide. The top bit names the bank (0 = bank A, 1 = bank B), and the low bits select the register inside that bank. The block compares this bank bit with the side that issued the access. From that it knows whether the access is local or crosses sides, flags any access the port is not allowed to make, and arbitrates the cross bus. Reads are combinational from the current contents. Writes land on the rising clock edge.

Two write ports exist, port 0 on side A and port 1 on side B. The scheduler is meant to keep two writes to one register on separate clocks. If they still meet on the same edge, the block resolves the clash in a fixed order and reports it. The block has no state machine: its only sequential state is the register contents and a one-cycle collision flag.

Top module: `dual_bank_rf`

## Requirements
- R1: While `rst_n` is low, every register of both banks is cleared to zero, and the cleared contents are readable once reset is released.
- R2: Local read port i of side s returns the current value of register `loc_addr[s][i][AW-2:0]` in bank s, combinationally, with `loc_err[s][i]` low, when the address bank bit equals s (A = 0, B = 1).
- R3: A local read whose address bank bit differs from its side sets `loc_err[s][i]` high and returns zero data.
- R4: A cross read request from side s whose address bank bit names the opposite bank, with no competing legal request, returns that register's value with `xr_valid[s]` high and `xr_conflict` low.
- R5: When both sides make legal cross reads in one cycle, side A (the lower number) is served. Side B gets `xr_valid[1]` low and zero data, and `xr_conflict` is high in that same cycle.
- R6: A cross read request whose address names the requester's own bank sets `xr_illegal[s]`, gives `xr_valid[s]` low and zero data, and does not compete for the cross bus.
- R7: A write on port p (0 = side A, 1 = side B) with `wr_en[p]` high stores `wr_data[p]` into the addressed register of either bank at the next rising edge, unless R8 or R9 drops it.
- R8: When both write ports target the opposite bank in one cycle, only port 0's write lands, port 1's write is dropped, and `xw_conflict` is high in that same cycle.
- R9: When both write ports target the same register on the same edge, the register takes port 0's data. `wr_collision` is high for exactly the one cycle after that edge.
- R10: A read of a register in the same cycle it is being written returns the old value; there is no write-through bypass.
- R11: Two writes in one cycle to different registers, with at most one of them crossing sides, both land and raise neither `xw_conflict` nor `wr_collision`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_addr | input | 2 x NLOC x AW | Local read addresses, indexed [side][port] |
| loc_data | output | 2 x NLOC x DW | Local read data |
| loc_err | output | 2 x NLOC | Local read addressed the other bank |
| xr_req | input | 2 | Cross read request per side |
| xr_addr | input | 2 x AW | Cross read address per side |
| xr_data | output | 2 x DW | Cross read data per side |
| xr_valid | output | 2 | Cross read served this cycle |
| xr_illegal | output | 2 | Cross read named the requester's own bank |
| xr_conflict | output | 1 | Both sides made legal cross reads this cycle |
| wr_en | input | 2 | Write enable, port 0 = side A, port 1 = side B |
| wr_addr | input | 2 x AW | Write address per port |
| wr_data | input | 2 x DW | Write data per port |
| xw_conflict | output | 1 | Both write ports crossed sides this cycle |
| wr_collision | output | 1 | Same-register write on the previous edge |

## Verification
The bench writes every register of both banks with a value that encodes its position. It alternates the write port so that half the writes cross sides, and it reads every register back through every local port. While each of those writes is still pending, it reads the register being written. A design with a bypass would show the new value there instead of the old one. It drives same-register collisions in both banks. A design that got the priority wrong would keep side B's value, and one that mistimed the flag would raise it in the wrong cycle or hold it for two. It also drives double cross reads, double cross writes and own-bank cross requests. A design that served both cross reads, let the dropped cross write through, or counted an illegal request as a competitor would return wrong data or a wrong valid bit.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    localparam int NSIDE = 2;

    // An access is cross-side when the bank bit differs from the issuing side.
    function automatic logic is_cross(input side_e side, input logic bank_bit);
        return bank_bit != logic'(side);
    endfunction

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int  NREG = 16,
    parameter int  DW   = 32,
    parameter int  NWP  = 2,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NWP-1:0]                wen,
    input  logic [NWP-1:0][RW-1:0]        waddr,
    input  logic [NWP-1:0][DW-1:0]        wdata,
    output logic [NREG-1:0][DW-1:0]       q
);

    // Lower-numbered ports are applied last, so they win on a shared register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int p = NWP - 1; p >= 0; p--) begin
                if (wen[p]) begin
                    q[waddr[p]] <= wdata[p];
                end
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q == '0 || $past(rst_n)));

endmodule

// File: rtl/rf_wr_ctrl.sv
module rf_wr_ctrl
    import rf_pkg::*;
#(
    parameter int  AW = 5,
    localparam int RW = AW - 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NSIDE-1:0]               wr_en,
    input  logic [NSIDE-1:0][AW-1:0]       wr_addr,
    output logic [NSIDE-1:0][NSIDE-1:0]    bank_wen,   // [bank][port]
    output logic                           xw_conflict,
    output logic                           wr_collision
);

    logic [NSIDE-1:0] crosses;
    logic [NSIDE-1:0] commit;
    logic             same_reg;

    always_comb begin
        crosses[0] = wr_en[0] && is_cross(SIDE_A, wr_addr[0][AW-1]);
        crosses[1] = wr_en[1] && is_cross(SIDE_B, wr_addr[1][AW-1]);
        xw_conflict = crosses[0] && crosses[1];
        same_reg = wr_en[0] && wr_en[1] && (wr_addr[0] == wr_addr[1]);
        commit[0] = wr_en[0];
        commit[1] = wr_en[1] && !xw_conflict && !same_reg;
        for (int b = 0; b < NSIDE; b++) begin
            for (int p = 0; p < NSIDE; p++) begin
                bank_wen[b][p] = commit[p] && (wr_addr[p][AW-1] == b[0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_collision <= 1'b0;
        end else begin
            wr_collision <= same_reg;
        end
    end

    // R8
    xw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_wen[0] | bank_wen[1]) <= 2 &&
        !(bank_wen[0][1] && bank_wen[1][0] && xw_conflict));

    // R9
    collision_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_collision && !same_reg |=> !wr_collision);

endmodule

// File: rtl/rf_xpath_rd.sv
module rf_xpath_rd
    import rf_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSIDE-1:0]           xr_req,
    input  logic [NSIDE-1:0][AW-1:0]   xr_addr,
    output logic [NSIDE-1:0]           grant,
    output logic [NSIDE-1:0]           xr_illegal,
    output logic                       xr_conflict
);

    logic [NSIDE-1:0] legal;

    always_comb begin
        legal[0]      = xr_req[0] && is_cross(SIDE_A, xr_addr[0][AW-1]);
        legal[1]      = xr_req[1] && is_cross(SIDE_B, xr_addr[1][AW-1]);
        xr_illegal    = xr_req & ~legal;
        xr_conflict   = legal[0] && legal[1];
        grant[0]      = legal[0];
        grant[1]      = legal[1] && !legal[0];
    end

    // R5
    xr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    xr_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xr_conflict |-> grant[0] && !grant[1]);

    // R6
    xr_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xr_illegal & grant) == '0);

endmodule

// File: rtl/dual_bank_rf.sv
module dual_bank_rf
    import rf_pkg::*;
#(
    parameter int  NREG = 16,
    parameter int  DW   = 32,
    parameter int  NLOC = 4,
    localparam int RW   = $clog2(NREG),
    localparam int AW   = RW + 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NSIDE-1:0][NLOC-1:0][AW-1:0]   loc_addr,
    output logic [NSIDE-1:0][NLOC-1:0][DW-1:0]   loc_data,
    output logic [NSIDE-1:0][NLOC-1:0]           loc_err,
    input  logic [NSIDE-1:0]                     xr_req,
    input  logic [NSIDE-1:0][AW-1:0]             xr_addr,
    output logic [NSIDE-1:0][DW-1:0]             xr_data,
    output logic [NSIDE-1:0]                     xr_valid,
    output logic [NSIDE-1:0]                     xr_illegal,
    output logic                                 xr_conflict,
    input  logic [NSIDE-1:0]                     wr_en,
    input  logic [NSIDE-1:0][AW-1:0]             wr_addr,
    input  logic [NSIDE-1:0][DW-1:0]             wr_data,
    output logic                                 xw_conflict,
    output logic                                 wr_collision
);

    logic [NSIDE-1:0][NREG-1:0][DW-1:0] q;
    logic [NSIDE-1:0][NSIDE-1:0]        bank_wen;
    logic [NSIDE-1:0][RW-1:0]           wr_reg;
    logic [NSIDE-1:0]                   xr_grant;

    always_comb begin
        for (int p = 0; p < NSIDE; p++) begin
            wr_reg[p] = wr_addr[p][RW-1:0];
        end
    end

    rf_wr_ctrl #(.AW(AW)) u_wr_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .bank_wen     (bank_wen),
        .xw_conflict  (xw_conflict),
        .wr_collision (wr_collision)
    );

    rf_xpath_rd #(.AW(AW)) u_xpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .xr_req      (xr_req),
        .xr_addr     (xr_addr),
        .grant       (xr_grant),
        .xr_illegal  (xr_illegal),
        .xr_conflict (xr_conflict)
    );

    for (genvar b = 0; b < NSIDE; b++) begin : g_bank
        rf_bank #(.NREG(NREG), .DW(DW), .NWP(NSIDE)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wen   (bank_wen[b]),
            .waddr (wr_reg),
            .wdata (wr_data),
            .q     (q[b])
        );
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        for (genvar i = 0; i < NLOC; i++) begin : g_port
            always_comb begin
                loc_err[s][i]  = loc_addr[s][i][AW-1] != 1'(s);
                loc_data[s][i] = loc_err[s][i] ? '0 : q[s][loc_addr[s][i][RW-1:0]];
            end

            // R3
            loc_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                loc_err[s][i] |-> loc_data[s][i] == '0);
        end

        always_comb begin
            xr_valid[s] = xr_grant[s];
            xr_data[s]  = xr_grant[s] ? q[1-s][xr_addr[s][RW-1:0]] : '0;
        end
    end

    logic same_target;
    assign same_target = wr_en[0] && wr_en[1] && (wr_addr[0] == wr_addr[1]);

    // R7
    port0_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[0] |=> q[$past(wr_addr[0][AW-1])][$past(wr_reg[0])] == $past(wr_data[0]));

    // R9
    collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        same_target |=> wr_collision);

    // R8
    xw_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xw_conflict |=> q[0][$past(wr_reg[1])] == $past(q[0][wr_reg[1]]));

endmodule

// File: tb/dual_bank_rf_tb.sv
module dual_bank_rf_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int NLOC = 4;
    localparam int RW   = $clog2(NREG);
    localparam int AW   = RW + 1;

    logic                        clk = 1'b0;
    logic                        rst_n;
    logic [1:0][NLOC-1:0][AW-1:0] loc_addr;
    logic [1:0][NLOC-1:0][DW-1:0] loc_data;
    logic [1:0][NLOC-1:0]         loc_err;
    logic [1:0]                   xr_req;
    logic [1:0][AW-1:0]           xr_addr;
    logic [1:0][DW-1:0]           xr_data;
    logic [1:0]                   xr_valid;
    logic [1:0]                   xr_illegal;
    logic                         xr_conflict;
    logic [1:0]                   wr_en;
    logic [1:0][AW-1:0]           wr_addr;
    logic [1:0][DW-1:0]           wr_data;
    logic                         xw_conflict;
    logic                         wr_collision;

    logic [DW-1:0] model [2][NREG];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_bank_rf #(.NREG(NREG), .DW(DW), .NLOC(NLOC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .loc_addr(loc_addr), .loc_data(loc_data), .loc_err(loc_err),
        .xr_req(xr_req), .xr_addr(xr_addr), .xr_data(xr_data),
        .xr_valid(xr_valid), .xr_illegal(xr_illegal), .xr_conflict(xr_conflict),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .xw_conflict(xw_conflict), .wr_collision(wr_collision)
    );

    function automatic logic [AW-1:0] mk(input int bank, input int r);
        return AW'(bank * NREG + r);
    endfunction

    function automatic logic [DW-1:0] pat(input int bank, input int r, input int p);
        return 32'h5A00_0000 ^ (DW'(bank) << 12) ^ (DW'(r) * 32'h0101_0101) ^ (DW'(p) << 20);
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < NLOC; i++) loc_addr[s][i] = mk(s, 0);
        end
        xr_req = '0; xr_addr = '0;
        wr_en = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_reg(input string req, input int bank, input int r);
        loc_addr[bank][0] = mk(bank, r);
        #1;
        chk(req, loc_data[bank][0], model[bank][r]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        for (int b = 0; b < 2; b++) for (int r = 0; r < NREG; r++) model[b][r] = '0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();

        // R1: all registers cleared
        for (int b = 0; b < 2; b++) for (int r = 0; r < NREG; r++) check_reg("R1", b, r);

        // R7 / R10: fill every register, alternating ports; check old value while pending
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < NREG; r++) begin
                int p = r % 2;
                idle();
                wr_en[p] = 1'b1;
                wr_addr[p] = mk(b, r);
                wr_data[p] = pat(b, r, p);
                loc_addr[b][1] = mk(b, r);
                #1;
                chk("R10", loc_data[b][1], model[b][r]);
                tick();
                model[b][r] = pat(b, r, p);
                idle();
                check_reg("R7", b, r);
            end
        end

        // R2: every register through every local port
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < NREG; r++) begin
                for (int i = 0; i < NLOC; i++) loc_addr[s][i] = mk(s, (r + i) % NREG);
                #1;
                for (int i = 0; i < NLOC; i++) begin
                    chk("R2", loc_data[s][i], model[s][(r + i) % NREG]);
                    chk("R2", DW'(loc_err[s][i]), '0);
                end
            end
        end

        // R3: local ports addressing the other bank
        idle();
        for (int s = 0; s < 2; s++) for (int i = 0; i < NLOC; i++) loc_addr[s][i] = mk(1 - s, i + 3);
        #1;
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < NLOC; i++) begin
                chk("R3", DW'(loc_err[s][i]), 1);
                chk("R3", loc_data[s][i], '0);
            end
        end

        // R4 / R5: cross reads alone and contended
        for (int r = 0; r < NREG; r++) begin
            idle();
            xr_req = 2'b01; xr_addr[0] = mk(1, r);
            #1;
            chk("R4", xr_data[0], model[1][r]);
            chk("R4", {30'd0, xr_conflict, xr_valid[0]}, 32'd1);
            xr_req = 2'b10; xr_addr[1] = mk(0, NREG - 1 - r);
            #1;
            chk("R4", xr_data[1], model[0][NREG - 1 - r]);
            chk("R4", DW'(xr_valid), 32'd2);
            xr_req = 2'b11;
            #1;
            chk("R5", xr_data[0], model[1][r]);
            chk("R5", xr_data[1], '0);
            chk("R5", {29'd0, xr_conflict, xr_valid}, 32'b101);
        end

        // R6: own-bank cross request is flagged and does not block the other side
        for (int r = 0; r < NREG; r += 5) begin
            idle();
            xr_req = 2'b11; xr_addr[0] = mk(0, r); xr_addr[1] = mk(0, r);
            #1;
            chk("R6", {28'd0, xr_illegal, xr_valid}, 32'b0110);
            chk("R6", DW'(xr_conflict), '0);
            chk("R6", xr_data[0], '0);
            chk("R6", xr_data[1], model[0][r]);
        end

        // R8: two cross writes in one cycle
        for (int r = 0; r < NREG; r += 3) begin
            idle();
            wr_en = 2'b11;
            wr_addr[0] = mk(1, r); wr_data[0] = ~pat(1, r, 7);
            wr_addr[1] = mk(0, r); wr_data[1] = ~pat(0, r, 9);
            #1;
            chk("R8", DW'(xw_conflict), 1);
            tick();
            model[1][r] = ~pat(1, r, 7);
            idle();
            check_reg("R8", 1, r);
            check_reg("R8", 0, r);
            chk("R8", DW'({xw_conflict, wr_collision}), '0);
        end

        // R9: same register on one edge, both banks
        for (int b = 0; b < 2; b++) begin
            for (int r = 1; r < NREG; r += 7) begin
                idle();
                wr_en = 2'b11;
                wr_addr[0] = mk(b, r); wr_data[0] = pat(b, r, 3) + 32'd1;
                wr_addr[1] = mk(b, r); wr_data[1] = pat(b, r, 5) + 32'd2;
                #1;
                chk("R9", DW'(wr_collision), '0);
                tick();
                model[b][r] = pat(b, r, 3) + 32'd1;
                idle();
                chk("R9", DW'(wr_collision), 1);
                check_reg("R9", b, r);
                tick();
                chk("R9", DW'(wr_collision), '0);
            end
        end

        // R11: two writes to different registers both land
        for (int r = 0; r < NREG; r += 4) begin
            idle();
            wr_en = 2'b11;
            wr_addr[0] = mk(0, r); wr_data[0] = pat(0, r, 11);
            wr_addr[1] = mk(1, r); wr_data[1] = pat(1, r, 13);
            #1;
            chk("R11", DW'(xw_conflict), '0);
            tick();
            model[0][r] = pat(0, r, 11);
            model[1][r] = pat(1, r, 13);
            idle();
            chk("R11", DW'(wr_collision), '0);
            check_reg("R11", 0, r);
            check_reg("R11", 1, r);
            wr_en = 2'b11;
            wr_addr[0] = mk(1, r); wr_data[0] = pat(1, r, 17);
            wr_addr[1] = mk(1, (r + 1) % NREG); wr_data[1] = pat(1, r, 19);
            #1;
            chk("R11", DW'(xw_conflict), '0);
            tick();
            model[1][r] = pat(1, r, 17);
            model[1][(r + 1) % NREG] = pat(1, r, 19);
            idle();
            chk("R11", DW'(wr_collision), '0);
            check_reg("R11", 1, r);
            check_reg("R11", 1, (r + 1) % NREG);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule